// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Configuration Select

This block sits between the board strap pins, the serial control register file and the synthesizer controls of a multi-output clock generator. While the power-on reset is held it samples a 3-bit frequency strap and a mode strap. When reset is released it freezes them, and later activity on those pins is ignored.

After reset it resolves the active configuration from two sources: the frozen straps and control byte 0 of the register file. It produces the following registered outputs:
- the effective frequency code and the matching CPU and PCI frequencies, in units of 100 kHz;
- the spread-spectrum enable, profile and depth;
- a request to three-state every clock output;
- the desktop/mobile flag. In desktop mode two shared pins carry memory clocks. In mobile mode they act as CPU-stop and PCI-stop inputs.

Top module: `clk_strap_select`

## Requirements
- R1: The strap values present at the last clock edge with `rst` high are kept until the next reset. Pin changes after reset release do not alter any output.
- R2: With control bit 3 at 0, `freq_code` equals the captured frequency strap.
- R3: With control bit 3 at 1, `freq_code` equals control bits 6:4, one clock after the byte is presented.
- R4: The CPU/PCI rates in 100 kHz units follow the code: 7→1002/334, 6→1330/332, 5→1121/373, 4→1030/343, 3→665/332, 2→833/416, 1→749/374, 0→947/316.
- R5: With control bit 3 at 0, `ss_enable` is 0 whatever bits 1, 2 and 7 hold.
- R6: With control bit 3 at 1, `ss_enable` follows bit 1, `ss_down` follows bit 2 (1 means down spread, 0 means center spread), and `ss_narrow` follows bit 7 (1 means ±0.5%, 0 means ±1.5%).
- R7: `tristate_req` follows control bit 0 one clock later, whatever the source selection.
- R8: `desktop_mode` equals the captured mode strap (1 means desktop, 0 means mobile).
- R9: At each clock edge with `rst` high, the outputs take the strap pin values. Spread is off and `tristate_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset; straps are captured while high |
| fs_pin | input | 3 | Frequency strap pins |
| mode_pin | input | 1 | Mode strap pin |
| ctrl_byte | input | 8 | Control byte 0 from the register file |
| freq_code | output | 3 | Effective frequency code |
| cpu_rate | output | 11 | CPU clock rate, 100 kHz units |
| pci_rate | output | 9 | PCI clock rate, 100 kHz units |
| ss_enable | output | 1 | Spread-spectrum enable |
| ss_down | output | 1 | Spread profile: 1 down, 0 center |
| ss_narrow | output | 1 | Spread depth: 1 for ±0.5%, 0 for ±1.5% |
| tristate_req | output | 1 | Request to float all clock outputs |
| desktop_mode | output | 1 | 1 desktop, 0 mobile |

## Verification
The bench builds the block with its default widths: a 3-bit code, an 8-bit control byte and 11-/9-bit rate fields. With these widths all eight codes and every control byte value are within reach of a random draw. Several resets with fresh random strap values exercise both mode settings and many captured codes. Between resets the strap pins keep changing, which tests that captured values survive pin activity.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int FS_W   = 3;
    localparam int CTRL_W = 8;
    localparam int CPU_W  = 11;
    localparam int PCI_W  = 9;

    // control byte bit positions
    localparam int BIT_TRI    = 0;
    localparam int BIT_SSEN   = 1;
    localparam int BIT_SSDOWN = 2;
    localparam int BIT_SRC    = 3;
    localparam int BIT_FS_LO  = 4;
    localparam int BIT_DEPTH  = 7;

    typedef struct packed {
        logic [FS_W-1:0] code;
        logic            desktop;
    } strap_t;

    typedef struct packed {
        logic [FS_W-1:0] code;
        logic            ss_en;
        logic            ss_down;
        logic            ss_narrow;
        logic            tristate;
        logic            desktop;
    } cfg_t;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [PCI_W-1:0] pci;
    } rate_t;

    function automatic rate_t rate_lookup(input logic [FS_W-1:0] c);
        rate_t r;
        case (c)
            3'd7:    begin r.cpu = 11'd1002; r.pci = 9'd334; end
            3'd6:    begin r.cpu = 11'd1330; r.pci = 9'd332; end
            3'd5:    begin r.cpu = 11'd1121; r.pci = 9'd373; end
            3'd4:    begin r.cpu = 11'd1030; r.pci = 9'd343; end
            3'd3:    begin r.cpu = 11'd665;  r.pci = 9'd332; end
            3'd2:    begin r.cpu = 11'd833;  r.pci = 9'd416; end
            3'd1:    begin r.cpu = 11'd749;  r.pci = 9'd374; end
            default: begin r.cpu = 11'd947;  r.pci = 9'd316; end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import clkcfg_pkg::*;
#(
    parameter int W = FS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] fs_pin,
    input  logic         mode_pin,
    output strap_t       strap_q
);
    // Capture register for each strap bit; loads only while reset is held.
    for (genvar i = 0; i < W; i++) begin : g_fs
        always_ff @(posedge clk) begin
            if (rst) strap_q.code[i] <= fs_pin[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) strap_q.desktop <= mode_pin;
    end
endmodule

// File: rtl/cfg_resolve.sv
module cfg_resolve
    import clkcfg_pkg::*;
(
    input  strap_t            strap,
    input  logic [CTRL_W-1:0] ctrl,
    output cfg_t              cfg
);
    logic use_reg;

    always_comb begin
        use_reg       = ctrl[BIT_SRC];
        cfg.code      = use_reg ? ctrl[BIT_FS_LO +: FS_W] : strap.code;
        cfg.ss_en     = use_reg & ctrl[BIT_SSEN];
        cfg.ss_down   = use_reg & ctrl[BIT_SSDOWN];
        cfg.ss_narrow = use_reg & ctrl[BIT_DEPTH];
        cfg.tristate  = ctrl[BIT_TRI];
        cfg.desktop   = strap.desktop;
    end
endmodule

// File: rtl/rate_decode.sv
module rate_decode
    import clkcfg_pkg::*;
(
    input  logic [FS_W-1:0] code,
    output rate_t           rate
);
    always_comb rate = rate_lookup(code);
endmodule

// File: rtl/clk_strap_select.sv
module clk_strap_select
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FS_W-1:0]   fs_pin,
    input  logic              mode_pin,
    input  logic [CTRL_W-1:0] ctrl_byte,
    output logic [FS_W-1:0]   freq_code,
    output logic [CPU_W-1:0]  cpu_rate,
    output logic [PCI_W-1:0]  pci_rate,
    output logic              ss_enable,
    output logic              ss_down,
    output logic              ss_narrow,
    output logic              tristate_req,
    output logic              desktop_mode
);
    strap_t          strap_q;
    cfg_t            cfg_d, cfg_q;
    cfg_t            cfg_rst;
    rate_t           rate_d, rate_q;
    logic [FS_W-1:0] latched_code;

    strap_latch #(.W(FS_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .fs_pin   (fs_pin),
        .mode_pin (mode_pin),
        .strap_q  (strap_q)
    );

    cfg_resolve u_resolve (
        .strap (strap_q),
        .ctrl  (ctrl_byte),
        .cfg   (cfg_d)
    );

    rate_decode u_rate (
        .code (cfg_d.code),
        .rate (rate_d)
    );

    always_comb begin
        cfg_rst           = '0;
        cfg_rst.code      = fs_pin;
        cfg_rst.desktop   = mode_pin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= cfg_rst;
            rate_q <= rate_lookup(fs_pin);
        end else begin
            cfg_q  <= cfg_d;
            rate_q <= rate_d;
        end
    end

    assign latched_code = strap_q.code;
    assign freq_code    = cfg_q.code;
    assign cpu_rate     = rate_q.cpu;
    assign pci_rate     = rate_q.pci;
    assign ss_enable    = cfg_q.ss_en;
    assign ss_down      = cfg_q.ss_down;
    assign ss_narrow    = cfg_q.ss_narrow;
    assign tristate_req = cfg_q.tristate;
    assign desktop_mode = cfg_q.desktop;
endmodule

// File: rtl/clk_strap_select_checker.sv
module clk_strap_select_checker
    import clkcfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl_byte,
    input logic [FS_W-1:0]   latched_code,
    input logic [FS_W-1:0]   freq_code,
    input logic [CPU_W-1:0]  cpu_rate,
    input logic [PCI_W-1:0]  pci_rate,
    input logic              ss_enable,
    input logic              ss_down,
    input logic              ss_narrow,
    input logic              tristate_req,
    input logic              desktop_mode
);
    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(desktop_mode));

    assert_strap_code_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl_byte[BIT_SRC])) |-> freq_code == $past(latched_code));

    assert_reg_code_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl_byte[BIT_SRC])) |-> freq_code == $past(ctrl_byte[BIT_FS_LO +: FS_W]));

    assert_rate_top_R4: assert property (@(posedge clk) disable iff (rst)
        (freq_code == 3'd6) |-> (cpu_rate == 11'd1330 && pci_rate == 9'd332));

    assert_rate_low_R4: assert property (@(posedge clk) disable iff (rst)
        (freq_code == 3'd3) |-> (cpu_rate == 11'd665 && pci_rate == 9'd332));

    assert_no_spread_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl_byte[BIT_SRC])) |-> !ss_enable && !ss_down && !ss_narrow);

    assert_spread_ctl_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl_byte[BIT_SRC])) |->
            (ss_enable == $past(ctrl_byte[BIT_SSEN]) && ss_down == $past(ctrl_byte[BIT_SSDOWN])
             && ss_narrow == $past(ctrl_byte[BIT_DEPTH])));

    assert_tristate_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tristate_req == $past(ctrl_byte[BIT_TRI]));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> !ss_enable && !tristate_req);
endmodule

bind clk_strap_select clk_strap_select_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_byte    (ctrl_byte),
    .latched_code (latched_code),
    .freq_code    (freq_code),
    .cpu_rate     (cpu_rate),
    .pci_rate     (pci_rate),
    .ss_enable    (ss_enable),
    .ss_down      (ss_down),
    .ss_narrow    (ss_narrow),
    .tristate_req (tristate_req),
    .desktop_mode (desktop_mode)
);

// File: tb/clk_strap_select_tb.sv
module clk_strap_select_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fs_pin = 3'd0;
    logic        mode_pin = 1'b0;
    logic [7:0]  ctrl_byte = 8'd0;
    logic [2:0]  freq_code;
    logic [10:0] cpu_rate;
    logic [8:0]  pci_rate;
    logic        ss_enable, ss_down, ss_narrow, tristate_req, desktop_mode;

    int checks = 0;
    int errors = 0;
    logic [2:0] lat_fs;
    logic       lat_mode;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    clk_strap_select u_dut (
        .clk(clk), .rst(rst), .fs_pin(fs_pin), .mode_pin(mode_pin),
        .ctrl_byte(ctrl_byte), .freq_code(freq_code), .cpu_rate(cpu_rate),
        .pci_rate(pci_rate), .ss_enable(ss_enable), .ss_down(ss_down),
        .ss_narrow(ss_narrow), .tristate_req(tristate_req), .desktop_mode(desktop_mode)
    );

    function automatic int exp_cpu(input logic [2:0] c);
        int t[8] = '{947, 749, 833, 665, 1030, 1121, 1330, 1002};
        return t[c];
    endfunction

    function automatic int exp_pci(input logic [2:0] c);
        int t[8] = '{316, 374, 416, 332, 343, 373, 332, 334};
        return t[c];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare all outputs against the bench model for the current byte
    task automatic check_all(input logic [7:0] b);
        logic [2:0] c;
        logic       src;
        src = b[3];
        c   = src ? b[6:4] : lat_fs;
        chk(src ? "R3 code" : "R2 code", freq_code, c);
        chk("R4 cpu rate", cpu_rate, exp_cpu(c));
        chk("R4 pci rate", pci_rate, exp_pci(c));
        if (src) begin
            chk("R6 ss_enable", ss_enable, b[1]);
            chk("R6 ss_down", ss_down, b[2]);
            chk("R6 ss_narrow", ss_narrow, b[7]);
        end else begin
            chk("R5 ss_enable", ss_enable, 0);
            chk("R5 ss_down", ss_down, 0);
            chk("R5 ss_narrow", ss_narrow, 0);
        end
        chk("R7 tristate", tristate_req, b[0]);
        chk("R8/R1 mode", desktop_mode, lat_mode);
    endtask

    task automatic do_reset(input logic [2:0] f, input logic m, input logic [7:0] b);
        @(negedge clk);
        rst = 1'b1; fs_pin = f; mode_pin = m; ctrl_byte = b;
        @(negedge clk);
        // R9: outputs during reset follow the pins, spread and float off
        chk("R9 code", freq_code, f);
        chk("R9 cpu", cpu_rate, exp_cpu(f));
        chk("R9 mode", desktop_mode, m);
        chk("R9 ss_enable", ss_enable, 0);
        chk("R9 tristate", tristate_req, 0);
        lat_fs = f; lat_mode = m;
        rst = 1'b0;
        // R1: move the pins at once; captured values must not follow
        fs_pin = ~f; mode_pin = ~m;
    endtask

    task automatic step(input logic [7:0] b, input logic [2:0] f, input logic m);
        ctrl_byte = b; fs_pin = f; mode_pin = m;
        @(negedge clk);
        check_all(b);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed: strap source, desktop, code 6
        do_reset(3'd6, 1'b1, 8'h00);
        step(8'h00, 3'd1, 1'b0);                 // R1, R2
        step(8'b1000_0110, 3'd2, 1'b0);          // R5: spread bits with strap source
        step(8'b1011_1110, 3'd0, 1'b1);          // R3 code 3, R6 all on
        step(8'b0000_1011, 3'd5, 1'b0);          // R3 code 0, tristate R7
        step(8'b0111_1001, 3'd7, 1'b1);          // code 7, tristate with reg source
        step(8'h01, 3'd3, 1'b0);                 // R7 tristate with strap source
        // directed: mobile mode, code 0
        do_reset(3'd0, 1'b0, 8'hFF);
        step(8'h00, 3'd7, 1'b1);
        step(8'hFF, 3'd6, 1'b1);
        // every code through register source (R4)
        for (int c = 0; c < 8; c++) step({1'b0, c[2:0], 4'b1000}, 3'(c), 1'b0);
        // random phases
        for (int r = 0; r < 12; r++) begin
            do_reset(3'($urandom), 1'($urandom), 8'($urandom));
            for (int k = 0; k < 40; k++)
                step(8'($urandom), 3'($urandom), 1'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule